// File: doc/BRIEF.md
# Packed Sub-Word Multiply-Add Unit

This unit runs one multiply-add per valid input on narrow operands taken from 32-bit register values. Operand A always comes from a register. Operand B comes from a second register or from a 16-bit immediate. A register operand is one byte lane or one 16-bit half. Each operand carries its own signedness, which sets how it is widened to 32 bits.

The unit forms A×B+C, where C is a full 32-bit addend. It can then shift the result right by 7 or 15. It can also report zero and negative flags for the result. Each result is registered and appears one clock after its input, marked by a valid strobe. If a used operand has an unsupported lane kind, the unit raises an error and returns zero.

Top module: `pvmad_unit`

## Requirements
- R1: With its half-select bit clear, a register operand is the 8-bit lane at bit offset 8×lane index, where the 2-bit lane index runs from 0 to 3.
- R2: With its half-select bit set, a register operand uses the 2-bit kind field. Kind 0 takes bits 15:0 and kind 1 takes bits 31:16.
- R3: Kinds 2 and 3 are illegal on an operand that is used. A is always used. B is used only when b_from_reg is 1. An illegal operand sets bad_operand to 1 and forces the result and both flags to 0. B's kind has no effect when B is the immediate.
- R4: A register operand is sign-extended to 32 bits when its own signed bit is 1. It is zero-extended when that bit is 0.
- R5: When b_from_reg is 0, B is imm16. It is sign-extended when b_signed is 1 and zero-extended when b_signed is 0.
- R6: Before any shift, the result is (A×B + C) truncated to 32 bits.
- R7: shift_sel selects the shift. 0 means none, 1 means right by 7, 2 means right by 15 and 3 means none. The shift is arithmetic when either operand is signed. It is logical when both operands are unsigned.
- R8: When want_flags is 1, flag_zero is 1 exactly when the result is 0, and flag_neg equals result bit 31. When want_flags is 0, both flags are 0.
- R9: result, the flags and bad_operand update on the clock edge that samples in_valid = 1. out_valid is in_valid delayed by one cycle. Without in_valid, the outputs hold their values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operation is valid |
| src_a | input | 32 | Register holding operand A |
| src_b | input | 32 | Register holding operand B |
| src_c | input | 32 | 32-bit addend |
| imm16 | input | 16 | Immediate for operand B |
| a_half | input | 1 | A uses a 16-bit half (1) or a byte lane (0) |
| a_kind | input | 2 | A half kind: 0 low, 1 high, 2/3 illegal |
| a_lane | input | 2 | A byte lane index |
| a_signed | input | 1 | A is signed |
| b_half | input | 1 | B uses a 16-bit half (1) or a byte lane (0) |
| b_kind | input | 2 | B half kind: 0 low, 1 high, 2/3 illegal |
| b_lane | input | 2 | B byte lane index |
| b_signed | input | 1 | B is signed |
| b_from_reg | input | 1 | B comes from src_b (1) or imm16 (0) |
| shift_sel | input | 2 | Shift select: 0 none, 1 by 7, 2 by 15, 3 none |
| want_flags | input | 1 | Produce zero and negative flags |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Registered result |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result bit 31 |
| bad_operand | output | 1 | Illegal operand kind was used |

## Verification
The stimulus table pulls bytes from several lane positions and both 16-bit halves. This shows that the offset and half selection are correct and not stuck on lane 0. The same small magnitudes are run as signed and unsigned, and the immediate as 0xFFFE/0xFFFF, so sign-extension and zero-extension give different products. Shifted cases put bit 31 high under both signed and unsigned modes to separate the arithmetic shift from the logical one. The error cases use an illegal kind on A, an illegal kind on B from a register, and an illegal kind on B while the immediate is in use, which must not raise the error. Directed steps check reset, holding without in_valid, and flag gating.

// File: rtl/pvmad_unit.sv
module pvmad_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] src_c,
  input  logic [15:0]  imm16,
  input  logic         a_half,
  input  logic [1:0]   a_kind,
  input  logic [1:0]   a_lane,
  input  logic         a_signed,
  input  logic         b_half,
  input  logic [1:0]   b_kind,
  input  logic [1:0]   b_lane,
  input  logic         b_signed,
  input  logic         b_from_reg,
  input  logic [1:0]   shift_sel,
  input  logic         want_flags,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_zero,
  output logic         flag_neg,
  output logic         bad_operand
);
  localparam int HW = W / 2;

  function automatic logic [W-1:0] pick(input logic [W-1:0] r, input logic half,
                                        input logic [1:0] kind, input logic [1:0] lane,
                                        input logic sgn);
    logic [7:0]    by;
    logic [HW-1:0] hw;
    by = 8'(r >> {lane, 3'b000});
    hw = kind[0] ? r[W-1:HW] : r[HW-1:0];
    if (!half) pick = sgn ? {{(W-8){by[7]}}, by} : {{(W-8){1'b0}}, by};
    else       pick = sgn ? {{(W-HW){hw[HW-1]}}, hw} : {{(W-HW){1'b0}}, hw};
  endfunction

  logic [W-1:0] op_a, op_b, sum, shifted, nxt;
  logic         signed_mode, bad;

  assign op_a = pick(src_a, a_half, a_kind, a_lane, a_signed);
  assign op_b = b_from_reg ? pick(src_b, b_half, b_kind, b_lane, b_signed)
              : (b_signed ? {{(W-16){imm16[15]}}, imm16} : {{(W-16){1'b0}}, imm16});
  assign signed_mode = a_signed | b_signed;
  assign bad = (a_half & a_kind[1]) | (b_from_reg & b_half & b_kind[1]);
  assign sum = W'(op_a * op_b) + src_c;

  always_comb begin
    case (shift_sel)
      2'd1:    shifted = signed_mode ? W'($signed(sum) >>> 7)  : sum >> 7;
      2'd2:    shifted = signed_mode ? W'($signed(sum) >>> 15) : sum >> 15;
      default: shifted = sum;
    endcase
  end

  assign nxt = bad ? '0 : shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      result      <= '0;
      flag_zero   <= 1'b0;
      flag_neg    <= 1'b0;
      bad_operand <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= nxt;
        bad_operand <= bad;
        flag_zero   <= want_flags & ~bad & (nxt == '0);
        flag_neg    <= want_flags & ~bad & nxt[W-1];
      end
    end
  end
endmodule

module pvmad_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         want_flags,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         flag_zero,
  input logic         flag_neg,
  input logic         bad_operand
);
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid delay");                        // R9
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid) else $error("valid drop");                       // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)) else $error("hold");                         // R9
  AST_BAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_operand |-> (result == '0 && !flag_zero && !flag_neg)) else $error("bad"); // R3
  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !want_flags) |=> (!flag_zero && !flag_neg)) else $error("gate"); // R8
  AST_NEG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_neg |-> result[W-1]) else $error("neg");                              // R8
  AST_ZERO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    flag_zero |-> (result == '0)) else $error("zero");                         // R8
endmodule

bind pvmad_unit pvmad_unit_chk #(.W(W)) chk_i (.*);

// File: tb/pvmad_unit_tb.sv
module pvmad_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        in_valid, a_half, a_signed, b_half, b_signed, b_from_reg, want_flags;
  logic [31:0] src_a, src_b, src_c;
  logic [15:0] imm16;
  logic [1:0]  a_kind, a_lane, b_kind, b_lane, shift_sel;
  logic        out_valid, flag_zero, flag_neg, bad_operand;
  logic [31:0] result;

  pvmad_unit dut_i (.*);

  typedef struct packed {
    logic [31:0] a, b, c; logic [15:0] imm;
    logic ah; logic [1:0] ak, al; logic as_;
    logic bh; logic [1:0] bk, bl; logic bs, breg;
    logic [1:0] sh; logic fl;
    logic [31:0] er; logic ez, en, eb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1 R6: byte lane 2 of A, lane 0 of B
    '{32'h11223344, 32'hAABBCCDD, 32'h100, 16'h0, 1'b0,2'd0,2'd2,1'b0, 1'b0,2'd0,2'd0,1'b0, 1'b1, 2'd0,1'b1, 32'h00001E5A,1'b0,1'b0,1'b0},
    // R4: signed byte -16 times unsigned lane 1 value 3
    '{32'h000000F0, 32'h00000300, 32'h0, 16'h0, 1'b0,2'd0,2'd0,1'b1, 1'b0,2'd0,2'd1,1'b0, 1'b1, 2'd0,1'b1, 32'hFFFFFFD0,1'b0,1'b1,1'b0},
    // R2: A high half, B low half, flags off
    '{32'h1234ABCD, 32'h0002FFFF, 32'h0, 16'h0, 1'b1,2'd1,2'd0,1'b0, 1'b1,2'd0,2'd0,1'b0, 1'b1, 2'd0,1'b0, 32'h1233EDCC,1'b0,1'b0,1'b0},
    // R5: immediate sign-extended
    '{32'h5, 32'h0, 32'd100, 16'hFFFE, 1'b0,2'd0,2'd0,1'b0, 1'b0,2'd0,2'd0,1'b1, 1'b0, 2'd0,1'b1, 32'h0000005A,1'b0,1'b0,1'b0},
    // R5: immediate zero-extended
    '{32'h5, 32'h0, 32'd100, 16'hFFFE, 1'b0,2'd0,2'd0,1'b0, 1'b0,2'd0,2'd0,1'b0, 1'b0, 2'd0,1'b1, 32'h0005005A,1'b0,1'b0,1'b0},
    // R7: arithmetic shift by 7
    '{32'h80, 32'h0, 32'h0, 16'h0001, 1'b0,2'd0,2'd0,1'b1, 1'b0,2'd0,2'd0,1'b1, 1'b0, 2'd1,1'b1, 32'hFFFFFFFF,1'b0,1'b1,1'b0},
    // R7: logical shift by 7
    '{32'h80, 32'h0, 32'h80000000, 16'hFFFF, 1'b0,2'd0,2'd0,1'b0, 1'b0,2'd0,2'd0,1'b0, 1'b0, 2'd1,1'b1, 32'h0100FFFF,1'b0,1'b0,1'b0},
    // R7: shift by 15, mixed signedness
    '{32'h00008000, 32'h00000002, 32'h0, 16'h0, 1'b1,2'd0,2'd0,1'b1, 1'b1,2'd0,2'd0,1'b0, 1'b1, 2'd2,1'b1, 32'hFFFFFFFE,1'b0,1'b1,1'b0},
    // R8: zero result, shift code 3
    '{32'h00FFFFFF, 32'h0, 32'h0, 16'h1234, 1'b0,2'd0,2'd3,1'b0, 1'b0,2'd0,2'd0,1'b0, 1'b0, 2'd3,1'b1, 32'h0,1'b1,1'b0,1'b0},
    // R3: illegal A kind 2
    '{32'h7, 32'h3, 32'h9, 16'h0, 1'b1,2'd2,2'd0,1'b0, 1'b0,2'd0,2'd0,1'b0, 1'b1, 2'd0,1'b1, 32'h0,1'b0,1'b0,1'b1},
    // R3: illegal B kind 3 from register
    '{32'h7, 32'h3, 32'h9, 16'h0, 1'b0,2'd0,2'd0,1'b0, 1'b1,2'd3,2'd0,1'b0, 1'b1, 2'd0,1'b1, 32'h0,1'b0,1'b0,1'b1},
    // R3: B kind 3 ignored with immediate
    '{32'h3, 32'h0, 32'h1, 16'h0004, 1'b0,2'd0,2'd0,1'b0, 1'b1,2'd3,2'd0,1'b0, 1'b0, 2'd0,1'b1, 32'h0000000D,1'b0,1'b0,1'b0}
  };

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic vld);
    src_a = v.a; src_b = v.b; src_c = v.c; imm16 = v.imm;
    a_half = v.ah; a_kind = v.ak; a_lane = v.al; a_signed = v.as_;
    b_half = v.bh; b_kind = v.bk; b_lane = v.bl; b_signed = v.bs;
    b_from_reg = v.breg; shift_sel = v.sh; want_flags = v.fl; in_valid = vld;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    apply(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    check("R9 reset result", result, 32'h0);
    check("R9 reset valid", {28'h0, out_valid, flag_zero, flag_neg, bad_operand}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R6 vec%0d result", i), result, VECS[i].er);
      check($sformatf("R8 vec%0d flags", i), {29'h0, flag_zero, flag_neg, bad_operand},
            {29'h0, VECS[i].ez, VECS[i].en, VECS[i].eb});
      check($sformatf("R9 vec%0d valid", i), {31'h0, out_valid}, 32'h1);
    end
    // R9: no valid, new inputs must not disturb the held result
    apply(VECS[0], 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R9 hold result", result, VECS[NV-1].er);
    check("R9 valid low", {31'h0, out_valid}, 32'h0);
    // R8: same nonzero negative result with flags disabled
    @(negedge clk);
    apply(VECS[1], 1'b1);
    want_flags = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 flags off result", result, 32'hFFFFFFD0);
    check("R8 flags off", {30'h0, flag_zero, flag_neg}, 32'h0);
    // R1: lane 3 of A
    @(negedge clk);
    apply(VECS[0], 1'b1);
    a_lane = 2'd3; src_c = 32'h0; b_lane = 2'd3;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 lane3", result, 32'h11 * 32'hAA);
    // R4: signed high half times unsigned immediate via R5
    @(negedge clk);
    apply(VECS[2], 1'b1);
    src_a = 32'hFFFE0000; a_signed = 1'b1; b_from_reg = 1'b0; imm16 = 16'h0003; src_c = 32'h0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 signed half", result, 32'hFFFFFFFA);
    // R3: illegal kind on unused B half but B lane mode is legal when half bit clear
    @(negedge clk);
    apply(VECS[10], 1'b1);
    b_half = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 kind ignored in byte mode", {31'h0, bad_operand}, 32'h0);
    check("R3 byte mode result", result, 32'h7 * 32'h3 + 32'h9);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule